// File: doc/BRIEF.md
# Cascaded CAM Priority Chain Slice

This block is the per-device glue that lets several associative-memory devices be stacked into one deeper search system. Each device owns one slice. The slice takes the local compare results of its device: hit, multiple hit, array full, and a side-table hit. At the close of each cycle it latches the flags that belong to that kind of cycle. It then joins three active-low links with its neighbours. The links report system hit, system multiple hit and system full. Flags pass from the highest-priority device at the head of the chain toward the lowest.

The links are resolved combinationally along the chain, so no clock cycles are spent in the cascade. A slice enables its data and address output drivers only for an access that reads the best match. It does so only when its own device has a hit and no device above it has one. This way exactly one device drives the shared buses. The head device has its hit and multiple-hit inputs tied inactive (high) and its full input tied active (low).

Top module: `cam_cascade_slice`

## Requirements
- R1: After reset the latched flags are clear. With inactive hit and multiple-hit inputs (high), `hit_out_n`, `multi_out_n`, `full_out_n` and `mvalid_n` are all high and `bus_drive` is low.
- R2: `hit_out_n` is low when `hit_in_n` is low or the latched local hit is set; otherwise it is high.
- R3: `multi_out_n` is low when `multi_in_n` is low, when the latched local multiple hit is set, or when the latched local hit is set while `hit_in_n` is low; otherwise it is high.
- R4: `full_out_n` is low only when `full_in_n` is low and the latched local full flag is set, so the last device in the chain reports a system-wide full.
- R5: `mvalid_n` is low only when the last compare cycle latched both a local hit and a table hit.
- R6: Hit, multiple-hit and match-valid are latched from the inputs present at the clock edge that sees `cyc_n` high after it was low, and only when `op` is compare (2'b01). They are visible from the next cycle. While `cyc_n` stays low, the outputs hold their previous values.
- R7: The full flag is latched in the same way only at the end of a write cycle (`op` = 2'b10). A compare cycle leaves it unchanged.
- R8: `bus_drive` is high exactly when `best_rd` is high, `oe_n` is low, `dev_sel` is high, the latched local hit is set and `hit_in_n` is high.
- R9: A cycle ending with `op` equal to 2'b00 or 2'b11 (idle or control-register access) changes no latched flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_n | input | 1 | Active-low cycle enable; its rising edge ends a cycle |
| op | input | 2 | Cycle kind: 00 idle, 01 compare, 10 write, 11 control |
| loc_hit | input | 1 | Local array hit from the compare engine |
| loc_multi | input | 1 | Local multiple hit |
| loc_full | input | 1 | Local array full |
| tbl_hit | input | 1 | Local side-table hit |
| hit_in_n | input | 1 | Hit link from the higher-priority device |
| multi_in_n | input | 1 | Multiple-hit link from the higher-priority device |
| full_in_n | input | 1 | Full link from the higher-priority device |
| best_rd | input | 1 | Current access reads the best match or status |
| oe_n | input | 1 | Active-low output enable |
| dev_sel | input | 1 | Device is selected |
| hit_out_n | output | 1 | Hit link toward lower-priority devices |
| multi_out_n | output | 1 | Multiple-hit link toward lower-priority devices |
| full_out_n | output | 1 | Full link toward lower-priority devices |
| mvalid_n | output | 1 | Local hit in both array and table |
| bus_drive | output | 1 | Enable for data and address drivers |

## Verification
Four slices are chained. Each is fed random hit, multiple-hit, full and table patterns, and the system outputs and the per-device drive enables are compared with a bench model of the chain. Patterns with a single hit, with hits in several devices, and with no hit at all tell true priority apart from a plain OR. Full patterns with one device not full show whether the links AND the full flags or OR them. Directed cases hold the cycle enable low, and they end idle and control cycles. These separate edge-triggered latching from level-triggered latching, and cycle-kind gating from blind capture.

// File: rtl/cam_chain_pkg.sv
package cam_chain_pkg;
  localparam int unsigned OP_W = 2;
  typedef enum logic [OP_W-1:0] {
    OP_IDLE = 2'b00,
    OP_CMP  = 2'b01,
    OP_WR   = 2'b10,
    OP_CTRL = 2'b11
  } cyc_op_e;

  typedef struct packed {
    logic hit;
    logic multi;
    logic full;
    logic mvalid;
  } loc_flags_t;
endpackage

// File: rtl/cam_rst_sync.sv
module cam_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cam_flag_latch.sv
module cam_flag_latch
  import cam_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_n,
  input  logic [OP_W-1:0]  op,
  input  logic             loc_hit,
  input  logic             loc_multi,
  input  logic             loc_full,
  input  logic             tbl_hit,
  output loc_flags_t       flags
);
  logic       cyc_q, cyc_d;
  loc_flags_t flg_q, flg_d;
  logic       cyc_end;
  logic       cmp_ld, wr_ld;

  assign cyc_end = cyc_n & ~cyc_q;
  assign cmp_ld  = cyc_end & (cyc_op_e'(op) == OP_CMP);
  assign wr_ld   = cyc_end & (cyc_op_e'(op) == OP_WR);

  always_comb begin
    cyc_d = cyc_n;
    flg_d = flg_q;
    if (cmp_ld) begin
      flg_d.hit    = loc_hit;
      flg_d.multi  = loc_multi;
      flg_d.mvalid = loc_hit & tbl_hit;
    end
    if (wr_ld) begin
      flg_d.full = loc_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= 1'b1;
      flg_q <= '0;
    end else begin
      cyc_q <= cyc_d;
      flg_q <= flg_d;
    end
  end

  assign flags = flg_q;
endmodule

// File: rtl/cam_chain_link.sv
module cam_chain_link
  import cam_chain_pkg::*;
(
  input  loc_flags_t flags,
  input  logic       hit_in_n,
  input  logic       multi_in_n,
  input  logic       full_in_n,
  output logic       hit_out_n,
  output logic       multi_out_n,
  output logic       full_out_n,
  output logic       mvalid_n,
  output logic       first_hit
);
  logic above_hit, above_multi, above_full;

  always_comb begin
    above_hit   = ~hit_in_n;
    above_multi = ~multi_in_n;
    above_full  = ~full_in_n;
    hit_out_n   = ~(above_hit | flags.hit);
    multi_out_n = ~(above_multi | flags.multi | (flags.hit & above_hit));
    full_out_n  = ~(above_full & flags.full);
    mvalid_n    = ~flags.mvalid;
    first_hit   = flags.hit & ~above_hit;
  end
endmodule

// File: rtl/cam_drive_gate.sv
module cam_drive_gate (
  input  logic first_hit,
  input  logic best_rd,
  input  logic oe_n,
  input  logic dev_sel,
  output logic bus_drive
);
  always_comb begin
    bus_drive = first_hit & best_rd & ~oe_n & dev_sel;
  end
endmodule

// File: rtl/cam_cascade_slice.sv
module cam_cascade_slice
  import cam_chain_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_n,
  input  logic [OP_W-1:0] op,
  input  logic            loc_hit,
  input  logic            loc_multi,
  input  logic            loc_full,
  input  logic            tbl_hit,
  input  logic            hit_in_n,
  input  logic            multi_in_n,
  input  logic            full_in_n,
  input  logic            best_rd,
  input  logic            oe_n,
  input  logic            dev_sel,
  output logic            hit_out_n,
  output logic            multi_out_n,
  output logic            full_out_n,
  output logic            mvalid_n,
  output logic            bus_drive
);
  logic       rst_int_n;
  loc_flags_t flags;
  logic       first_hit;

  cam_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  cam_flag_latch u_latch (
    .clk(clk), .rst_n(rst_int_n), .cyc_n(cyc_n), .op(op),
    .loc_hit(loc_hit), .loc_multi(loc_multi), .loc_full(loc_full),
    .tbl_hit(tbl_hit), .flags(flags)
  );

  cam_chain_link u_link (
    .flags(flags), .hit_in_n(hit_in_n), .multi_in_n(multi_in_n),
    .full_in_n(full_in_n), .hit_out_n(hit_out_n),
    .multi_out_n(multi_out_n), .full_out_n(full_out_n),
    .mvalid_n(mvalid_n), .first_hit(first_hit)
  );

  cam_drive_gate u_gate (
    .first_hit(first_hit), .best_rd(best_rd), .oe_n(oe_n),
    .dev_sel(dev_sel), .bus_drive(bus_drive)
  );
endmodule

// File: rtl/cam_cascade_slice_chk.sv
module cam_cascade_slice_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_n,
  input logic hit_in_n,
  input logic multi_in_n,
  input logic full_in_n,
  input logic best_rd,
  input logic oe_n,
  input logic dev_sel,
  input logic hit_out_n,
  input logic multi_out_n,
  input logic full_out_n,
  input logic mvalid_n,
  input logic bus_drive
);
  AST_HIT_PROPAGATES: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_in_n |-> !hit_out_n); // R2
  AST_MULTI_PROPAGATES: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_in_n |-> !multi_out_n); // R3
  AST_FULL_NEEDS_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    full_in_n |-> full_out_n); // R4
  AST_MVALID_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !mvalid_n |-> !hit_out_n); // R5
  AST_MVALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(cyc_n) |=> $stable(mvalid_n)); // R6
  AST_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (hit_in_n && !oe_n && dev_sel && best_rd && !hit_out_n)); // R8
endmodule

bind cam_cascade_slice cam_cascade_slice_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .hit_in_n(hit_in_n),
  .multi_in_n(multi_in_n), .full_in_n(full_in_n), .best_rd(best_rd),
  .oe_n(oe_n), .dev_sel(dev_sel), .hit_out_n(hit_out_n),
  .multi_out_n(multi_out_n), .full_out_n(full_out_n),
  .mvalid_n(mvalid_n), .bus_drive(bus_drive)
);

// File: tb/tb_cam_cascade_slice.sv
module tb_cam_cascade_slice;
  localparam int N = 4;

  logic clk, rst_n, cyc_n, best_rd, oe_n;
  logic [1:0] op;
  logic [N-1:0] lh, lm, lf, lt, sel;
  logic [N:0] hn, mn, fn;
  logic [N-1:0] mvn, drv;
  int checks = 0, fails = 0;
  bit em[N], emm[N], ef[N], et[N];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign hn[0] = 1'b1;
  assign mn[0] = 1'b1;
  assign fn[0] = 1'b0;

  cam_cascade_slice dut (
    .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .op(op),
    .loc_hit(lh[0]), .loc_multi(lm[0]), .loc_full(lf[0]), .tbl_hit(lt[0]),
    .hit_in_n(hn[0]), .multi_in_n(mn[0]), .full_in_n(fn[0]),
    .best_rd(best_rd), .oe_n(oe_n), .dev_sel(sel[0]),
    .hit_out_n(hn[1]), .multi_out_n(mn[1]), .full_out_n(fn[1]),
    .mvalid_n(mvn[0]), .bus_drive(drv[0])
  );

  for (genvar i = 1; i < N; i++) begin : g_lo
    cam_cascade_slice u_slice (
      .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .op(op),
      .loc_hit(lh[i]), .loc_multi(lm[i]), .loc_full(lf[i]), .tbl_hit(lt[i]),
      .hit_in_n(hn[i]), .multi_in_n(mn[i]), .full_in_n(fn[i]),
      .best_rd(best_rd), .oe_n(oe_n), .dev_sel(sel[i]),
      .hit_out_n(hn[i+1]), .multi_out_n(mn[i+1]), .full_out_n(fn[i+1]),
      .mvalid_n(mvn[i]), .bus_drive(drv[i])
    );
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected system outputs {hit_n, multi_n, full_n}
  function automatic logic [2:0] exp_sys();
    bit h = 0, m = 0, f = 1;
    for (int i = 0; i < N; i++) begin
      m = m | emm[i] | (em[i] & h);
      h = h | em[i];
      f = f & ef[i];
    end
    return {~h, ~m, ~f};
  endfunction

  function automatic logic [N-1:0] exp_drv();
    logic [N-1:0] r = '0;
    bit h = 0;
    for (int i = 0; i < N; i++) begin
      r[i] = em[i] & ~h & best_rd & ~oe_n & sel[i];
      h = h | em[i];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_mv();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = ~(em[i] & et[i]);
    return r;
  endfunction

  task automatic run_cycle(input logic [1:0] k);
    @(negedge clk); op = k; cyc_n = 1'b0;
    @(negedge clk); cyc_n = 1'b1;
    @(negedge clk); op = 2'b00;
    for (int i = 0; i < N; i++) begin
      if (k == 2'b01) begin em[i] = lh[i]; emm[i] = lm[i]; et[i] = lt[i]; end
      if (k == 2'b10) ef[i] = lf[i];
    end
  endtask

  task automatic check_all(input string tag);
    logic [2:0] es;
    es = exp_sys();
    chk(hn[N] == es[2], {tag, " R2 hit"}, hn[N], es[2]);
    chk(mn[N] == es[1], {tag, " R3 multi"}, mn[N], es[1]);
    chk(fn[N] == es[0], {tag, " R4 full"}, fn[N], es[0]);
    chk(mvn == exp_mv(), {tag, " R5 mvalid"}, mvn, exp_mv());
    chk(drv == exp_drv(), {tag, " R8 drive"}, drv, exp_drv());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cyc_n = 1'b1; op = 2'b00; best_rd = 1'b1; oe_n = 1'b0;
    lh = '0; lm = '0; lf = '0; lt = '0; sel = '1;
    for (int i = 0; i < N; i++) begin em[i] = 0; emm[i] = 0; ef[i] = 0; et[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(hn[N] && mn[N] && fn[N], "R1 links idle", {hn[N], mn[N], fn[N]}, 3'b111);
    chk(mvn == '1 && drv == '0, "R1 mvalid/drive", {mvn, drv}, {4'hF, 4'h0});

    // R6: cycle enable held low, nothing latched yet
    lh = 4'b0100; lm = 4'b0000; lt = 4'b0100;
    @(negedge clk); op = 2'b01; cyc_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(hn[N] == 1'b1, "R6 no latch while low", hn[N], 1);
    cyc_n = 1'b1;
    @(negedge clk); op = 2'b00;
    em[2] = 1; et[2] = 1;
    chk(hn[N] == 1'b0, "R6 latched at rise", hn[N], 0);
    check_all("R6 single");

    // R7: compare does not touch full; write does
    lf = '1;
    run_cycle(2'b01);
    chk(fn[N] == 1'b1, "R7 compare keeps full", fn[N], 1);
    lh = '0; lm = '0; lt = '0;
    run_cycle(2'b10);
    chk(fn[N] == 1'b0, "R7 write sets full", fn[N], 0);
    chk(hn[N] == 1'b0, "R7 write keeps hit", hn[N], 0);
    check_all("R7");

    // R9: idle and control cycles change nothing
    lf = '0; lh = '1; lm = '1; lt = '1;
    @(negedge clk); op = 2'b11; cyc_n = 1'b0;
    @(negedge clk); cyc_n = 1'b1;
    @(negedge clk); op = 2'b00;
    check_all("R9 ctrl");
    @(negedge clk); op = 2'b00; cyc_n = 1'b0;
    @(negedge clk); cyc_n = 1'b1;
    @(negedge clk);
    check_all("R9 idle");

    // R3: two hits, no local multi -> system multi
    lh = 4'b1010; lm = '0; lt = 4'b0010;
    run_cycle(2'b01);
    chk(mn[N] == 1'b0, "R3 two hits", mn[N], 0);
    chk(drv == 4'b0010, "R8 top hit drives", drv, 4'b0010);
    check_all("R3");

    // R4: one device not full
    lf = 4'b1101;
    run_cycle(2'b10);
    chk(fn[N] == 1'b1, "R4 partial full", fn[N], 1);

    // R8 gating by oe_n / sel / best_rd
    oe_n = 1'b1; @(negedge clk); check_all("R8 oe");
    oe_n = 1'b0; sel = 4'b1101; @(negedge clk); check_all("R8 sel");
    sel = '1; best_rd = 1'b0; @(negedge clk); check_all("R8 rd");
    best_rd = 1'b1;

    // random mix
    for (int t = 0; t < 60; t++) begin
      lh = 4'($urandom); lm = 4'($urandom) & 4'($urandom); lt = 4'($urandom);
      lf = 4'($urandom) | 4'($urandom);
      run_cycle(2'($urandom_range(0, 3)));
      run_cycle(2'($urandom_range(0, 3)));
      sel = 4'($urandom) | 4'($urandom); oe_n = ($urandom_range(0, 3) == 0);
      best_rd = ($urandom_range(0, 3) != 0);
      @(negedge clk);
      check_all("rand");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule